// File: doc/BRIEF.md
# Sticky Flag Interrupt Controller

This block collects ten interrupt causes into latched flags and drives a single level-sensitive interrupt request to a processor. The flags sit in two banks. One bank holds the local causes: a timer overflow, falling edges on two external pins and an internal keyboard-report tick. The other bank holds bus events: IN completion on endpoints 0, 1 and 2, OUT completion on endpoint 0, SETUP reception and suspend detection. Each bank has three byte registers: a read-only status byte, a write-only clear byte and a read/write enable byte.

Only hardware can set a flag. Software acknowledges a flag by writing a 1 to the matching bit of the clear byte. A flag whose enable bit is 0 stays visible in the status byte but does not request an interrupt. The keyboard tick comes from a free-running counter. With the default count of 24,000 cycles it fires every 4 ms on a 6 MHz clock, and a parameter shortens this count for simulation. The external pins are raw asynchronous inputs. They pass through a synchronizer before edge detection.

Top module: `irq_gather`

## Requirements
- R1: After reset every status bit and every enable bit reads 0 and `irq` is 0.
- R2: Bank A sits at offsets 0 (status), 1 (clear) and 2 (enable). Its bit 0 is the timer event, bit 1 external pin 0, bit 2 external pin 1 and bit 3 the keyboard tick.
- R3: Bank B sits at offsets 3 (status), 4 (clear) and 5 (enable). Its bit 0 is IN endpoint 0, bit 1 OUT endpoint 0, bit 2 IN endpoint 1, bit 3 IN endpoint 2, bit 6 SETUP and bit 7 suspend. A one-cycle event pulse sets its flag at that clock edge.
- R4: Writing 1 to a bit of a clear byte clears that flag, and writing 0 leaves the flag unchanged. A write to a status offset changes nothing.
- R5: A falling edge on an external pin sets its flag at the third rising clock edge after the pin changes (two synchronizer stages, then the edge register). A rising edge sets nothing.
- R6: The keyboard-tick flag is set once every `TICK_CYCLES` clock cycles.
- R7: `irq` equals the OR, across both banks, of each flag ANDed with its enable bit. A set flag whose enable bit is 0 stays readable but keeps `irq` low. `irq` falls only after a register write.
- R8: When an event and a clear of the same flag arrive in the same cycle, the flag ends up set.
- R9: Unused bit positions read 0. Clear offsets and offsets 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe for the current offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current offset (combinational) |
| ev_timer | input | 1 | Timer overflow pulse |
| ext_pin0 | input | 1 | External pin 0, asynchronous, idles high |
| ext_pin1 | input | 1 | External pin 1, asynchronous, idles high |
| ev_in_ep0 | input | 1 | IN done on endpoint 0, one-cycle pulse |
| ev_out_ep0 | input | 1 | OUT done on endpoint 0, one-cycle pulse |
| ev_in_ep1 | input | 1 | IN done on endpoint 1, one-cycle pulse |
| ev_in_ep2 | input | 1 | IN done on endpoint 2, one-cycle pulse |
| ev_setup | input | 1 | SETUP received, one-cycle pulse |
| ev_suspend | input | 1 | Suspend detected, one-cycle pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that the event inputs are synchronous pulses that last exactly one cycle, and that the external pins idle high when reset is released. The stimulus meets these assumptions in three ways. It raises every event for exactly one cycle, between falling clock edges. It holds both pins high through reset. It changes a pin only at a falling edge and then waits several cycles before checking. The tick count is cut to a small value so that the tick interval can be measured exactly.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        OFS_A_STAT = 3'd0,
        OFS_A_CLR  = 3'd1,
        OFS_A_EN   = 3'd2,
        OFS_B_STAT = 3'd3,
        OFS_B_CLR  = 3'd4,
        OFS_B_EN   = 3'd5
    } reg_ofs_e;

    localparam int A_TIMER = 0;
    localparam int A_PIN0  = 1;
    localparam int A_PIN1  = 2;
    localparam int A_TICK  = 3;

    localparam int B_IN0   = 0;
    localparam int B_OUT0  = 1;
    localparam int B_IN1   = 2;
    localparam int B_IN2   = 3;
    localparam int B_SETUP = 6;
    localparam int B_SUSP  = 7;

    localparam logic [REG_W-1:0] A_MASK = 8'h0F;
    localparam logic [REG_W-1:0] B_MASK = 8'hCF;

    typedef struct packed {
        logic [REG_W-1:0] status;
        logic [REG_W-1:0] enable;
    } bank_state_t;
endpackage

// File: rtl/irq_gather_edge.sv
module irq_gather_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pin_i;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign fall_o = s_q.prev & ~s_q.chain[SYNC_STAGES-1];

    assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/irq_gather_tick.sv
module irq_gather_tick #(
    parameter int TICK_CYCLES = 24000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tick_state_t;

    tick_state_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.tick = (t_q.cnt == LAST);
        t_d.cnt  = (t_q.cnt == LAST) ? '0 : t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tick_o = t_q.tick;

    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/irq_gather_bank.sv
module irq_gather_bank
    import irq_gather_pkg::*;
#(
    parameter logic [REG_W-1:0] MASK = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic             en_wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] status_o,
    output logic [REG_W-1:0] enable_o,
    output logic             pend_o
);
    bank_state_t b_d, b_q;

    always_comb begin
        logic [REG_W-1:0] clr_bits;
        b_d      = b_q;
        clr_bits = clr_wr_i ? wdata_i : '0;
        b_d.status = ((b_q.status & ~clr_bits) | set_i) & MASK;
        if (en_wr_i) begin
            b_d.enable = wdata_i & MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign status_o = b_q.status;
    assign enable_o = b_q.enable;
    assign pend_o   = |(b_q.status & b_q.enable);

    // R4: no flag rises without its hardware event
    assert_hw_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_i)) == '0));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr_i |=> ((status_o & $past(wdata_i & ~set_i)) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & MASK)) |=> ((status_o & $past(set_i & MASK)) == $past(set_i & MASK)));
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int TICK_CYCLES = 24000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_timer,
    input  logic       ext_pin0,
    input  logic       ext_pin1,
    input  logic       ev_in_ep0,
    input  logic       ev_out_ep0,
    input  logic       ev_in_ep1,
    input  logic       ev_in_ep2,
    input  logic       ev_setup,
    input  logic       ev_suspend,
    output logic       irq
);
    logic [1:0]       pin_fall;
    logic [1:0]       pin_raw;
    logic             tick;
    logic [REG_W-1:0] set_a, set_b;
    logic [REG_W-1:0] stat_a, stat_b, en_a, en_b;
    logic             pend_a, pend_b;

    assign pin_raw = {ext_pin1, ext_pin0};

    for (genvar p = 0; p < 2; p++) begin : g_pin
        irq_gather_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (pin_raw[p]),
            .fall_o(pin_fall[p])
        );
    end

    irq_gather_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    always_comb begin
        set_a          = '0;
        set_a[A_TIMER] = ev_timer;
        set_a[A_PIN0]  = pin_fall[0];
        set_a[A_PIN1]  = pin_fall[1];
        set_a[A_TICK]  = tick;
        set_b          = '0;
        set_b[B_IN0]   = ev_in_ep0;
        set_b[B_OUT0]  = ev_out_ep0;
        set_b[B_IN1]   = ev_in_ep1;
        set_b[B_IN2]   = ev_in_ep2;
        set_b[B_SETUP] = ev_setup;
        set_b[B_SUSP]  = ev_suspend;
    end

    irq_gather_bank #(.MASK(A_MASK)) u_bank_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_a),
        .clr_wr_i(reg_wr && (reg_addr == OFS_A_CLR)),
        .en_wr_i (reg_wr && (reg_addr == OFS_A_EN)),
        .wdata_i (reg_wdata),
        .status_o(stat_a),
        .enable_o(en_a),
        .pend_o  (pend_a)
    );

    irq_gather_bank #(.MASK(B_MASK)) u_bank_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_b),
        .clr_wr_i(reg_wr && (reg_addr == OFS_B_CLR)),
        .en_wr_i (reg_wr && (reg_addr == OFS_B_EN)),
        .wdata_i (reg_wdata),
        .status_o(stat_b),
        .enable_o(en_b),
        .pend_o  (pend_b)
    );

    always_comb begin
        case (reg_addr)
            OFS_A_STAT: reg_rdata = stat_a;
            OFS_A_EN:   reg_rdata = en_a;
            OFS_B_STAT: reg_rdata = stat_b;
            OFS_B_EN:   reg_rdata = en_b;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = pend_a | pend_b;

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr));
endmodule

// File: tb/irq_gather_test.sv
module irq_gather_test;
    localparam int TICK = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ev_timer = 0, ext_pin0 = 1, ext_pin1 = 1;
    logic       ev_in_ep0 = 0, ev_out_ep0 = 0, ev_in_ep1 = 0, ev_in_ep2 = 0;
    logic       ev_setup = 0, ev_suspend = 0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_gather #(.TICK_CYCLES(TICK)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_timer(ev_timer),
        .ext_pin0(ext_pin0), .ext_pin1(ext_pin1), .ev_in_ep0(ev_in_ep0),
        .ev_out_ep0(ev_out_ep0), .ev_in_ep1(ev_in_ep1), .ev_in_ep2(ev_in_ep2),
        .ev_setup(ev_setup), .ev_suspend(ev_suspend), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic fire(input int bank, input int b);
        @(negedge clk);
        if (bank == 0) begin
            if (b == 0) ev_timer = 1;
        end else begin
            case (b)
                0: ev_in_ep0 = 1;
                1: ev_out_ep0 = 1;
                2: ev_in_ep1 = 1;
                3: ev_in_ep2 = 1;
                6: ev_setup = 1;
                7: ev_suspend = 1;
                default: ;
            endcase
        end
        @(negedge clk);
        {ev_timer, ev_in_ep0, ev_out_ep0, ev_in_ep1, ev_in_ep2, ev_setup, ev_suspend} = '0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int t[3];
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset reg", int'(d & ((a == 0) ? 8'hF7 : 8'hFF)), 0);
        end
        chk("R1 reset irq", int'(irq), 0);

        // R9 enable read-back masks and unmapped offsets
        wr(3'd2, 8'hFF); rd(3'd2, d); chk("R9 R2 bank A enable mask", int'(d), 8'h0F);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R9 R3 bank B enable mask", int'(d), 8'hCF);
        wr(3'd2, 8'h00); wr(3'd5, 8'h00);
        rd(3'd1, d); chk("R9 clear A reads 0", int'(d), 0);
        rd(3'd4, d); chk("R9 clear B reads 0", int'(d), 0);
        rd(3'd6, d); chk("R9 offset 6", int'(d), 0);
        rd(3'd7, d); chk("R9 offset 7", int'(d), 0);

        // R3 bank B sweep, R7 irq per source
        for (int b = 0; b < 8; b++) begin
            logic [7:0] exp_bit;
            exp_bit = ((8'hCF >> b) & 8'h01) << b;
            wr(3'd4, 8'hFF);
            fire(1, b);
            rd(3'd3, d); chk("R3 bank B flag position", int'(d), int'(exp_bit));
            chk("R7 disabled flag no irq", int'(irq), 0);
            wr(3'd5, 8'(1 << b));
            #1 chk("R7 enabled flag irq", int'(irq), int'(exp_bit != 0));
            wr(3'd4, 8'(1 << b));
            #1 chk("R7 irq after clear", int'(irq), 0);
            wr(3'd5, 8'h00);
        end

        // R2 timer bit in bank A
        wr(3'd1, 8'h07);
        fire(0, 0);
        rd(3'd0, d); chk("R2 timer flag bit0", int'(d & 8'h07), 1);

        // R4 writing 0 to clear and writing status have no effect
        wr(3'd1, 8'hFE); rd(3'd0, d); chk("R4 clear with 0 keeps flag", int'(d & 8'h07), 1);
        wr(3'd0, 8'h00); rd(3'd0, d); chk("R4 status write ignored", int'(d & 8'h07), 1);
        wr(3'd4, 8'hFF); wr(3'd3, 8'hFF); rd(3'd3, d); chk("R4 status B write ignored", int'(d), 0);
        wr(3'd1, 8'h01); rd(3'd0, d); chk("R4 clear with 1", int'(d & 8'h07), 0);

        // R8 set beats clear in same cycle
        @(negedge clk);
        ev_suspend = 1; reg_addr = 3'd4; reg_wdata = 8'h80; reg_wr = 1;
        @(negedge clk);
        ev_suspend = 0; reg_wr = 0;
        rd(3'd3, d); chk("R8 set wins", int'(d), 8'h80);
        wr(3'd5, 8'h80); #1 chk("R7 irq suspend", int'(irq), 1);
        wr(3'd4, 8'h80); wr(3'd5, 8'h00);

        // R5 external pins
        wr(3'd1, 8'h06);
        @(negedge clk); ext_pin0 = 0;
        @(negedge clk); @(negedge clk);
        rd(3'd0, d); chk("R5 pin0 not before third edge", int'(d & 8'h06), 0);
        @(negedge clk);
        rd(3'd0, d); chk("R5 pin0 fall sets bit1", int'(d & 8'h06), 2);
        wr(3'd1, 8'h02);
        @(negedge clk); ext_pin0 = 1;
        repeat (5) @(negedge clk);
        rd(3'd0, d); chk("R5 pin0 rise no flag", int'(d & 8'h06), 0);
        @(negedge clk); ext_pin1 = 0;
        repeat (4) @(negedge clk);
        rd(3'd0, d); chk("R5 pin1 fall sets bit2", int'(d & 8'h06), 4);
        @(negedge clk); ext_pin1 = 1;
        wr(3'd1, 8'h04);

        // R6 tick interval
        wr(3'd1, 8'h08);
        k = 0;
        for (int i = 0; i < 10 * TICK && k < 3; i++) begin
            @(negedge clk);
            rd(3'd0, d);
            if (d[3]) begin
                t[k] = cyc;
                k++;
                wr(3'd1, 8'h08);
            end
        end
        chk("R6 tick seen three times", k, 3);
        chk("R6 tick period 1", t[1] - t[0], TICK);
        chk("R6 tick period 2", t[2] - t[1], TICK);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule